// File: doc/BRIEF.md
# Page-Latched Nonvolatile Write Controller

This block sits behind a serial memory front end that has already decoded the bus framing. It receives a command start carrying a 16-bit word address, then a stream of data bytes, each marked by a one-cycle strobe. The bytes are gathered in a 128-byte page latch. When the command ends with a stop event, the block copies the latched bytes into a byte-wide memory array. The copy runs as one self-timed write cycle, and the write-protect input can veto it. While the cycle runs, a busy flag is raised. The front end uses that flag to refuse new commands, which is how acknowledge polling works.

Only the low 7 bits of the pointer advance as bytes arrive, so a burst always stays inside its physical page. A burst longer than the page wraps and overwrites its own earlier bytes. A per-slot valid mask makes sure that only slots loaded during the current command reach the array.

The array is a synchronous RAM model with a registered read port. Its index uses the low `MEM_AW` bits of the pointer. The write-cycle length is the parameter `WRITE_CYCLES`, counted in clock cycles.

The control state machine has three states:
- `PW_IDLE`: waiting for a command.
- `PW_LOAD`: collecting data bytes.
- `PW_BUSY`: running the self-timed commit.

Its transitions are:
- IDLE→LOAD on start.
- LOAD→LOAD on a repeated start.
- LOAD→BUSY on a stop with write-protect low and at least one byte loaded.
- LOAD→IDLE on a stop with write-protect high or with no bytes loaded.
- BUSY→IDLE once `WRITE_CYCLES` cycles have elapsed.

Top module: `pwc_top`

## Requirements
- R1: After reset, `busy_o` is 0, `ptr_o` is 0 and the array is not written.
- R2: A start outside the busy period loads `ptr_o` from `cmd_addr_i` and clears the valid mask. A repeated start while loading therefore discards the bytes loaded so far.
- R3: While loading, each strobed byte (not accompanied by a start or stop) is stored in page slot `ptr_o[6:0]`. Then `ptr_o[6:0]` increments modulo 128 and `ptr_o[15:7]` is unchanged. After the last byte, `ptr_o` names the next location in the same page.
- R4: When more than 128 bytes arrive before the stop, the later bytes overwrite the earlier bytes in the same slots.
- R5: The array is written only during the busy period. The commit writes exactly the slots loaded since the last start, to array index `{ptr_o[MEM_AW-1:7], slot}`. Every other location keeps its value.
- R6: `wp_i` is sampled only in the stop cycle:
  - If it is 1 at the stop, nothing is written, `busy_o` stays 0 and a new command is accepted on the next cycle.
  - Its value while bytes load has no effect.
  - Its value after the stop has no effect.
- R7: After an accepted stop, `busy_o` is 1 from the following cycle for exactly `WRITE_CYCLES` cycles.
- R8: Start, stop and data strobes during the busy period are ignored. `ptr_o`, the committed data and the busy length are unaffected.
- R9: A stop with no byte loaded raises no busy period and writes nothing. Data strobes and stops while idle have no effect.
- R10: `rd_data_o` shows the array byte at `rd_addr_i` one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | One-cycle command start event |
| cmd_addr_i | input | 16 | Starting word address, sampled with start |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_data_i | input | 8 | Data byte |
| wp_i | input | 1 | Write-protect, sampled at stop |
| cmd_stop_i | input | 1 | One-cycle command stop event |
| rd_addr_i | input | MEM_AW | Array read address |
| rd_data_o | output | 8 | Array read data, one cycle latency |
| busy_o | output | 1 | Self-timed write cycle in progress |
| ptr_o | output | 16 | Current address pointer |

## Verification
The assertions check the following on every cycle:
- an accepted stop with write-protect low and loaded bytes raises busy;
- a protected or empty stop does not raise busy;
- array writes happen only while busy and stay inside the pointer's page;
- the pointer is frozen while busy;
- each byte strobe advances only the in-page bits.

The following can only be shown by the bench scenarios, which read back the whole array after each command:
- which bytes reach the array, including page wrap and overrun;
- the exact busy length;
- that disturbing events during busy leave the commit intact.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_LOAD = 2'd1,
        PW_BUSY = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
    parameter int PAGE_AW = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      wr_i,
    input  logic [PAGE_AW-1:0]        wr_idx_i,
    input  logic [pwc_pkg::BYTE_W-1:0] wr_data_i,
    input  logic [PAGE_AW-1:0]        rd_idx_i,
    output logic [pwc_pkg::BYTE_W-1:0] rd_data_o,
    output logic                      rd_valid_o,
    output logic                      any_valid_o
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    logic [pwc_pkg::BYTE_W-1:0] slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]      mask_q;

    // data slots carry no reset; the mask alone says which are meaningful
    always_ff @(posedge clk) begin
        if (wr_i) slot_q[wr_idx_i] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask_q <= '0;
        else if (clr_i)  mask_q <= '0;
        else if (wr_i)   mask_q[wr_idx_i] <= 1'b1;
    end

    always_comb begin
        rd_data_o   = slot_q[rd_idx_i];
        rd_valid_o  = mask_q[rd_idx_i];
        any_valid_o = |mask_q;
    end
endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
    parameter int AW = 10
) (
    input  logic                       clk,
    input  logic                       we_i,
    input  logic [AW-1:0]              waddr_i,
    input  logic [pwc_pkg::BYTE_W-1:0] wdata_i,
    input  logic [AW-1:0]              raddr_i,
    output logic [pwc_pkg::BYTE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [pwc_pkg::BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
        rdata_o <= mem_q[raddr_i];
    end
endmodule

// File: rtl/pwc_top.sv
module pwc_top #(
    parameter int ADDR_W       = 16,
    parameter int PAGE_AW      = 7,
    parameter int MEM_AW       = 10,
    parameter int WRITE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_data_i,
    input  logic              wp_i,
    input  logic              cmd_stop_i,
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] ptr_o
);
    import pwc_pkg::*;

    localparam int PAGE_BYTES = 1 << PAGE_AW;
    // counter must reach both the sweep end and the cycle length
    localparam int CNT_W = $clog2(WRITE_CYCLES + PAGE_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(PAGE_BYTES);

    pw_state_e         state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              accept_byte, clr_mask, sweeping;
    logic [7:0]        slot_data;
    logic              slot_valid, any_valid;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;

    // start/stop win over a data strobe in the same cycle
    assign accept_byte = (state_q == PW_LOAD) && byte_valid_i && !cmd_start_i && !cmd_stop_i;
    assign clr_mask    = (state_q != PW_BUSY) && cmd_start_i;
    assign sweeping    = (state_q == PW_BUSY) && (cnt_q < SWEEP_END);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE: if (cmd_start_i) state_d = PW_LOAD;
            PW_LOAD: begin
                if (cmd_start_i)     state_d = PW_LOAD;
                else if (cmd_stop_i) state_d = (!wp_i && any_valid) ? PW_BUSY : PW_IDLE;
            end
            PW_BUSY: if (cnt_q == LAST_CNT) state_d = PW_IDLE;
            default: state_d = PW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PW_IDLE;
        else        state_q <= state_d;
    end

    // pointer and cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            if (clr_mask)
                ptr_q <= cmd_addr_i;
            else if (accept_byte)
                ptr_q <= {ptr_q[ADDR_W-1:PAGE_AW], ptr_q[PAGE_AW-1:0] + 1'b1};
            if (state_q == PW_BUSY) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q == PW_BUSY);
        ptr_o     = ptr_q;
        mem_we    = sweeping && slot_valid;
        mem_waddr = {ptr_q[MEM_AW-1:PAGE_AW], cnt_q[PAGE_AW-1:0]};
    end

    pwc_page_buf #(.PAGE_AW(PAGE_AW)) page_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_mask),
        .wr_i        (accept_byte),
        .wr_idx_i    (ptr_q[PAGE_AW-1:0]),
        .wr_data_i   (byte_data_i),
        .rd_idx_i    (cnt_q[PAGE_AW-1:0]),
        .rd_data_o   (slot_data),
        .rd_valid_o  (slot_valid),
        .any_valid_o (any_valid)
    );

    pwc_array #(.AW(MEM_AW)) array_i (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (slot_data),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    // R5: array written only inside the busy window, and only within the pointer's page
    a_r5_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy_o);
    a_r5_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_waddr[MEM_AW-1:PAGE_AW] == ptr_o[MEM_AW-1:PAGE_AW]));
    // R7: an accepted unprotected stop with loaded bytes starts busy
    a_r7_stop_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_LOAD && cmd_stop_i && !cmd_start_i && !wp_i && any_valid) |=> busy_o);
    // R6: a protected stop leaves busy low
    a_r6_protect_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_LOAD && cmd_stop_i && !cmd_start_i && wp_i) |=> !busy_o);
    // R9: an empty stop leaves busy low
    a_r9_empty_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_LOAD && cmd_stop_i && !cmd_start_i && !any_valid) |=> !busy_o);
    // R8: pointer frozen throughout busy
    a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ptr_o));
    // R3: a byte strobe moves only the in-page bits, by one
    a_r3_in_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        accept_byte |=> (ptr_o[ADDR_W-1:PAGE_AW] == $past(ptr_o[ADDR_W-1:PAGE_AW]))
                     && (ptr_o[PAGE_AW-1:0] == PAGE_AW'($past(ptr_o[PAGE_AW-1:0]) + 1'b1)));
endmodule

// File: tb/pwc_top_tb_top.sv
module pwc_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_AW     = 10;
    localparam int DEPTH      = 1 << MEM_AW;
    localparam int WCYC       = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start_i = 1'b0;
    logic [15:0] cmd_addr_i = '0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_data_i = '0;
    logic        wp_i = 1'b0;
    logic        cmd_stop_i = 1'b0;
    logic [MEM_AW-1:0] rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic        busy_o;
    logic [15:0] ptr_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0]  ref_mem [DEPTH];
    logic [7:0]  pbuf [128];
    bit          pval [128];
    logic [15:0] mptr = '0;
    bit          loading = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwc_top #(.MEM_AW(MEM_AW), .WRITE_CYCLES(WCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .cmd_addr_i(cmd_addr_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .wp_i(wp_i),
        .cmd_stop_i(cmd_stop_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .busy_o(busy_o), .ptr_o(ptr_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [15:0] a);
        @(negedge clk);
        cmd_start_i = 1'b1; cmd_addr_i = a;
        @(posedge clk); #1 cmd_start_i = 1'b0;
        mptr = a; loading = 1;
        for (int i = 0; i < 128; i++) pval[i] = 0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(negedge clk);
        byte_valid_i = 1'b1; byte_data_i = d;
        @(posedge clk); #1 byte_valid_i = 1'b0;
        if (loading) begin
            pbuf[mptr[6:0]] = d; pval[mptr[6:0]] = 1;
            mptr[6:0] = mptr[6:0] + 7'd1;
        end
    endtask

    // stop with a given protect level; optionally pester the block while busy
    task automatic do_stop(input logic wp, input bit disturb, input string req);
        int  exp_busy, cnt, base;
        bit  any;
        any = 0;
        for (int i = 0; i < 128; i++) if (pval[i]) any = 1;
        exp_busy = (loading && !wp && any) ? WCYC : 0;
        if (exp_busy != 0) begin
            base = (int'(mptr) % DEPTH) & ~127;
            for (int i = 0; i < 128; i++) if (pval[i]) ref_mem[base + i] = pbuf[i];
        end
        loading = 0;
        @(negedge clk);
        cmd_stop_i = 1'b1; wp_i = wp;
        @(posedge clk); #1 cmd_stop_i = 1'b0; wp_i = 1'b0;
        cnt = 0;
        @(negedge clk);
        while (busy_o && cnt < WCYC + 50) begin
            cmd_start_i = 1'b0; byte_valid_i = 1'b0; cmd_stop_i = 1'b0;
            if (disturb) begin
                if (cnt == 3)  begin cmd_start_i = 1'b1; cmd_addr_i = 16'h3A5C; end
                if (cnt == 5)  begin byte_valid_i = 1'b1; byte_data_i = 8'hEE; end
                if (cnt == 7)  cmd_stop_i = 1'b1;
                if (cnt == 140) begin cmd_start_i = 1'b1; cmd_addr_i = 16'h0011; end
                if (cnt == 142) cmd_stop_i = 1'b1;
                wp_i = (cnt >= 4 && cnt < 120);
                if (cnt == 10) check("R8 ptr frozen while busy", int'(ptr_o), int'(mptr));
            end
            cnt++;
            @(negedge clk);
        end
        cmd_start_i = 1'b0; byte_valid_i = 1'b0; cmd_stop_i = 1'b0; wp_i = 1'b0;
        check({req, " busy length"}, cnt, exp_busy);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); rd_addr_i = MEM_AW'(a);
            @(negedge clk); check({req, " R10 array readback"}, int'(rd_data_o), int'(ref_mem[a]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy after reset", int'(busy_o), 0);
        check("R1 ptr after reset", int'(ptr_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 busy idle", int'(busy_o), 0);

        // R5 R7: fill every page; upper pointer bits above the array alias away
        for (int p = 0; p < DEPTH / 128; p++) begin
            do_start(16'((p << 7) | 16'h8000));
            for (int i = 0; i < 128; i++) do_byte(8'((p * 37 + i * 5 + 1) & 255));
            check("R3 full page ptr wraps to page base", int'(ptr_o), int'(mptr));
            do_stop(1'b0, 0, "R7 full page");
        end
        sweep("R5 full fill");

        // R3 single byte write, pointer lands on next location
        do_start(16'h0155); do_byte(8'hA1);
        check("R3 single byte ptr", int'(ptr_o), 16'h0156);
        do_stop(1'b0, 0, "R7 single byte");
        do_start(16'h01FF); do_byte(8'hB2);
        check("R3 ptr wraps inside page", int'(ptr_o), 16'h0180);
        do_stop(1'b0, 0, "R7 last slot");
        // R5 partial page: unloaded slots untouched
        do_start(16'h02B0);
        for (int i = 0; i < 10; i++) do_byte(8'(8'h40 + i));
        do_stop(1'b0, 0, "R5 partial");
        sweep("R5 single and partial");

        // R4 overrun of 140 bytes from offset 0x70
        do_start(16'h0370);
        for (int i = 0; i < 140; i++) do_byte(8'(i * 3 + 7));
        check("R4 ptr after overrun", int'(ptr_o), int'(mptr));
        do_stop(1'b0, 0, "R4 overrun");
        sweep("R4 overrun");

        // R6 protected at stop: dropped, no busy, immediately ready
        do_start(16'h0090);
        for (int i = 0; i < 20; i++) do_byte(8'(8'hC0 ^ i));
        do_stop(1'b1, 0, "R6 protected");
        do_start(16'h0010);
        check("R6 new command accepted at once", int'(ptr_o), 16'h0010);
        do_byte(8'h5A);
        // R6 protect high while loading, low at stop: commits
        @(negedge clk); wp_i = 1'b1;
        do_byte(8'h5B);
        do_stop(1'b0, 0, "R6 protect during load");
        sweep("R6 protect");

        // R8 disturbance during busy, protect toggles after stop
        do_start(16'h0220);
        for (int i = 0; i < 6; i++) do_byte(8'(8'h90 + i));
        do_stop(1'b0, 1, "R8 disturbed");
        check("R8 ptr after disturbed busy", int'(ptr_o), int'(mptr));

        // R2 restart discards earlier bytes
        do_start(16'h0180);
        for (int i = 0; i < 5; i++) do_byte(8'h11);
        do_start(16'h01C0); do_byte(8'h77);
        check("R2 restart reloads ptr", int'(ptr_o), 16'h01C1);
        do_stop(1'b0, 0, "R2 restart");
        sweep("R2 R8 restart and disturb");

        // R9 empty stop and idle strobes
        do_start(16'h0300);
        do_stop(1'b0, 0, "R9 empty stop");
        do_byte(8'hFF);
        check("R9 idle byte ignored ptr", int'(ptr_o), 16'h0300);
        do_stop(1'b0, 0, "R9 idle stop");
        sweep("R9 idle");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule